// File: doc/BRIEF.md
# Multi-Line Atomic Event Controller

This block manages a single multi-line atomic event inside a core. Each locked load names a cache line that joins the event, and the block keeps a small table of those lines. Stores that the core issues to a joined line are not sent to memory. They are held in a store buffer instead. When the core issues a store marked with the lock flag to a joined line, that store closes the event, and every held store is presented on the memory write port in one cycle.

The block also watches incoming snoops for interference and decides how the event ends. There are three outcomes. The event commits, or it restarts at its first instruction, or it diverts to the failure target.

The core can issue an interference query. Before the query, a snoop that hits a joined line kills the event and forces a restart. After the query, the block guards the remaining stores: a snoop that hits a joined line is refused with a NAK, and the event carries on. Once guarded, the only killing interference is a NAK that the fabric returns to one of this core's own requests, and that diverts the event. Once an event finishes, either way, the line table and the store buffer are empty again.

Top module: `atomic_event_ctrl`

## Requirements
- R1: A locked load (req_op 0) while idle starts an event, and evt_active is high from the next cycle. Up to 8 distinct lines can join. A locked load to a ninth distinct line ends the event: evt_done pulses the cycle after that load, evt_result is 3 (divert), and evt_active drops.
- R2: A line is the address with its low 2 bits dropped. A locked load or a store to any address inside a joined line counts as that line and takes no new table entry. An unlocked store (req_op 1, req_lock 0) to a line that has not joined is ignored and is never written.
- R3: mem_we stays low while an event is in progress. A failed event never raises mem_we.
- R4: A locked store to a joined line commits the event. In the next cycle, and only in that cycle, mem_we is high, evt_done is high and evt_result is 1. Slot i of mem_waddr/mem_wdata holds the i-th distinct store address of the event, mem_wmask has its low N bits set for N stored addresses, and a repeated store to an address rewrites that slot's data in place.
- R5: A store that would need a ninth distinct buffer slot diverts the event (result 3) without writing.
- R6: A locked store to a line that has not joined abandons the event with result 3. That store is not written.
- R7: Without a prior query (req_op 2), a snoop that hits a joined line gets snp_nak low and makes the event end with result 2 (restart) in the next cycle.
- R8: After a query, evt_guarded is high. A snoop that hits a joined line gets snp_nak high in the same cycle and the event continues. own_nak then ends the event with result 3.
- R9: own_nak during an unguarded event ends it with result 2. own_nak while idle has no effect.
- R10: A snoop that misses every joined line gets snp_nak low and leaves the event untouched.
- R11: After any completion, lines from the previous event no longer match. Snoops to them are not refused, and stores to them are not buffered.
- R12: After reset, evt_active, evt_guarded, evt_done, snp_nak and mem_we are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request valid |
| req_op | input | 2 | 0 locked load, 1 store, 2 interference query, 3 none |
| req_lock | input | 1 | Lock flag on a store (ends the event) |
| req_addr | input | ADDR_W | Request byte address |
| req_data | input | DATA_W | Store data |
| own_nak | input | 1 | Fabric refused one of this core's requests |
| snp_valid | input | 1 | Incoming snoop valid |
| snp_addr | input | ADDR_W | Snoop address |
| snp_nak | output | 1 | Snoop refused (same cycle) |
| evt_active | output | 1 | Event in progress |
| evt_guarded | output | 1 | Interference query has executed |
| evt_done | output | 1 | One-cycle outcome pulse |
| evt_result | output | 2 | 1 commit, 2 restart, 3 divert |
| mem_we | output | 1 | Commit write strobe for all slots |
| mem_wmask | output | SB_DEPTH | Valid slots in the commit |
| mem_waddr | output | SB_DEPTH*ADDR_W | Slot addresses, slot 0 in the low bits |
| mem_wdata | output | SB_DEPTH*DATA_W | Slot data, slot 0 in the low bits |

## Verification
A corrupted line table shows up at the ports in one of three ways:
- a snoop is refused that should pass, or passes when it should be refused, in the same cycle;
- a load to a line that has already joined diverts the event one cycle later;
- a line is missing from the commit.

A store buffer error is only visible at commit, as a wrong mask, a wrong slot order or stale data, so every swept event ends with a commit that is compared slot by slot. A stuck state or guard flag shows either as an outcome code that disagrees with whether a query was issued, or as a stale match in the event that follows.

// File: rtl/atev_pkg.sv
package atev_pkg;
    typedef enum logic [1:0] {
        OP_LLOAD = 2'd0,
        OP_STORE = 2'd1,
        OP_QUERY = 2'd2,
        OP_NONE  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        RES_NONE    = 2'd0,
        RES_COMMIT  = 2'd1,
        RES_RESTART = 2'd2,
        RES_DIVERT  = 2'd3
    } res_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_COMMIT = 2'd2
    } st_e;

    typedef struct packed {
        st_e  st;
        logic guard;
        logic done;
        res_e res;
    } ctl_t;
endpackage

// File: rtl/atev_line_tab.sv
module atev_line_tab #(
    parameter int LINE_AW = 10,
    parameter int NLINES  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               ins,
    input  logic [LINE_AW-1:0] ins_line,
    input  logic [LINE_AW-1:0] q_line,
    input  logic [LINE_AW-1:0] s_line,
    output logic               q_hit,
    output logic               s_hit,
    output logic               full
);
    logic [NLINES-1:0]  vld_q, vld_d;
    logic [LINE_AW-1:0] tag_q [NLINES];
    logic [LINE_AW-1:0] tag_d [NLINES];
    logic [NLINES-1:0]  qm, sm;

    for (genvar g = 0; g < NLINES; g++) begin : g_cmp
        assign qm[g] = vld_q[g] && (tag_q[g] == q_line);
        assign sm[g] = vld_q[g] && (tag_q[g] == s_line);
    end

    assign q_hit = |qm;
    assign s_hit = |sm;
    assign full  = &vld_q;

    always_comb begin
        logic placed;
        placed = 1'b0;
        vld_d  = vld_q;
        tag_d  = tag_q;
        if (clr) begin
            vld_d = '0;
        end else if (ins) begin
            for (int i = 0; i < NLINES; i++) begin
                if (!placed && !vld_q[i]) begin
                    vld_d[i] = 1'b1;
                    tag_d[i] = ins_line;
                    placed   = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= vld_d;
    end

    always_ff @(posedge clk) begin
        tag_q <= tag_d;
    end

    // R1: the controller never inserts into a full table
    p_ins_room_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ins && !clr) |-> !full);
    // R11: a clear leaves no line matching
    p_clear_empties_r11: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (vld_q == '0));
endmodule

// File: rtl/atev_st_buf.sv
module atev_st_buf #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr,
    input  logic                      wr,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [DATA_W-1:0]         wr_data,
    output logic                      would_ovf,
    output logic [DEPTH-1:0]          vld,
    output logic [DEPTH*ADDR_W-1:0]   addr_flat,
    output logic [DEPTH*DATA_W-1:0]   data_flat
);
    logic [DEPTH-1:0]  vld_q, vld_d;
    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [ADDR_W-1:0] addr_d [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];
    logic [DATA_W-1:0] data_d [DEPTH];
    logic [DEPTH-1:0]  am;
    logic              hit;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        assign am[g] = vld_q[g] && (addr_q[g] == wr_addr);
        assign addr_flat[g*ADDR_W +: ADDR_W] = addr_q[g];
        assign data_flat[g*DATA_W +: DATA_W] = data_q[g];
    end

    assign hit       = |am;
    assign would_ovf = !hit && (&vld_q);
    assign vld       = vld_q;

    always_comb begin
        logic placed;
        placed = 1'b0;
        vld_d  = vld_q;
        addr_d = addr_q;
        data_d = data_q;
        if (clr) begin
            vld_d = '0;
        end else if (wr) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (hit) begin
                    if (am[i]) data_d[i] = wr_data;
                end else if (!placed && !vld_q[i]) begin
                    vld_d[i]  = 1'b1;
                    addr_d[i] = wr_addr;
                    data_d[i] = wr_data;
                    placed    = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= vld_d;
    end

    always_ff @(posedge clk) begin
        addr_q <= addr_d;
        data_q <= data_d;
    end

    // R4: occupied slots always form a contiguous run from slot 0
    p_slot_prefix_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((vld_q & (vld_q + DEPTH'(1))) == '0));
    // R5: the controller never writes when no slot is free
    p_no_ovf_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !clr) |-> !would_ovf);
endmodule

// File: rtl/atomic_event_ctrl.sv
module atomic_event_ctrl
    import atev_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 8,
    parameter int LINE_OFS_W = 2,
    parameter int MAX_LINES  = 8,
    parameter int SB_DEPTH   = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    input  logic [1:0]                   req_op,
    input  logic                         req_lock,
    input  logic [ADDR_W-1:0]            req_addr,
    input  logic [DATA_W-1:0]            req_data,
    input  logic                         own_nak,
    input  logic                         snp_valid,
    input  logic [ADDR_W-1:0]            snp_addr,
    output logic                         snp_nak,
    output logic                         evt_active,
    output logic                         evt_guarded,
    output logic                         evt_done,
    output logic [1:0]                   evt_result,
    output logic                         mem_we,
    output logic [SB_DEPTH-1:0]          mem_wmask,
    output logic [SB_DEPTH*ADDR_W-1:0]   mem_waddr,
    output logic [SB_DEPTH*DATA_W-1:0]   mem_wdata
);
    localparam int LINE_AW = ADDR_W - LINE_OFS_W;

    ctl_t ctl_q, ctl_d;
    logic tab_ins, tab_clr, q_hit, s_hit, tab_full;
    logic sb_wr, sb_ovf;
    logic [SB_DEPTH-1:0] sb_vld;
    logic [LINE_AW-1:0]  req_line, snp_line;
    op_e  op;

    assign req_line = req_addr[ADDR_W-1:LINE_OFS_W];
    assign snp_line = snp_addr[ADDR_W-1:LINE_OFS_W];
    assign op       = op_e'(req_op);

    atev_line_tab #(.LINE_AW(LINE_AW), .NLINES(MAX_LINES)) u_tab (
        .clk(clk), .rst_n(rst_n), .clr(tab_clr), .ins(tab_ins),
        .ins_line(req_line), .q_line(req_line), .s_line(snp_line),
        .q_hit(q_hit), .s_hit(s_hit), .full(tab_full)
    );

    atev_st_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(SB_DEPTH)) u_sb (
        .clk(clk), .rst_n(rst_n), .clr(tab_clr), .wr(sb_wr),
        .wr_addr(req_addr), .wr_data(req_data), .would_ovf(sb_ovf),
        .vld(sb_vld), .addr_flat(mem_waddr), .data_flat(mem_wdata)
    );

    always_comb begin
        logic fail;
        res_e fail_res;
        fail     = 1'b0;
        fail_res = RES_DIVERT;
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        ctl_d.res  = RES_NONE;
        tab_ins  = 1'b0;
        tab_clr  = 1'b0;
        sb_wr    = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid && op == OP_LLOAD) begin
                    tab_ins     = 1'b1;
                    ctl_d.st    = ST_ACTIVE;
                    ctl_d.guard = 1'b0;
                end
            end
            ST_ACTIVE: begin
                if (snp_valid && s_hit && !ctl_q.guard) begin
                    fail     = 1'b1;
                    fail_res = RES_RESTART;
                end else if (own_nak) begin
                    fail     = 1'b1;
                    fail_res = ctl_q.guard ? RES_DIVERT : RES_RESTART;
                end else if (req_valid) begin
                    case (op)
                        OP_LLOAD: begin
                            if (!q_hit) begin
                                if (tab_full) fail = 1'b1;
                                else          tab_ins = 1'b1;
                            end
                        end
                        OP_STORE: begin
                            if (q_hit) begin
                                if (sb_ovf) begin
                                    fail = 1'b1;
                                end else begin
                                    sb_wr = 1'b1;
                                    if (req_lock) begin
                                        ctl_d.st   = ST_COMMIT;
                                        ctl_d.done = 1'b1;
                                        ctl_d.res  = RES_COMMIT;
                                    end
                                end
                            end else if (req_lock) begin
                                fail = 1'b1;
                            end
                        end
                        OP_QUERY: ctl_d.guard = 1'b1;
                        default: ;
                    endcase
                end
            end
            ST_COMMIT: begin
                tab_clr     = 1'b1;
                ctl_d.st    = ST_IDLE;
                ctl_d.guard = 1'b0;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
        if (fail) begin
            tab_clr     = 1'b1;
            tab_ins     = 1'b0;
            sb_wr       = 1'b0;
            ctl_d.st    = ST_IDLE;
            ctl_d.guard = 1'b0;
            ctl_d.done  = 1'b1;
            ctl_d.res   = fail_res;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, guard: 1'b0, done: 1'b0, res: RES_NONE};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign evt_active  = (ctl_q.st == ST_ACTIVE);
    assign evt_guarded = ctl_q.guard;
    assign evt_done    = ctl_q.done;
    assign evt_result  = ctl_q.res;
    assign mem_we      = (ctl_q.st == ST_COMMIT);
    assign mem_wmask   = mem_we ? sb_vld : '0;
    assign snp_nak     = snp_valid && s_hit &&
                         ((ctl_q.st == ST_ACTIVE && ctl_q.guard) || ctl_q.st == ST_COMMIT);

    // R4: the commit strobe always coincides with the commit outcome
    p_commit_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (evt_done && evt_result == RES_COMMIT));
    // R4: outcomes are single-cycle pulses
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        evt_done |=> !evt_done);
    // R3: a failed outcome is never accompanied by a write
    p_fail_nowrite_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_done && evt_result != RES_COMMIT) |-> !mem_we);
    // R8: refusals only while guarded or committing
    p_nak_guard_r8: assert property (@(posedge clk) disable iff (!rst_n)
        snp_nak |-> (evt_guarded || mem_we));
    // R7: an unguarded hit snoop restarts the event
    p_unguarded_kill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_active && !evt_guarded && snp_valid && s_hit) |=>
        (evt_done && evt_result == RES_RESTART));
endmodule

// File: tb/tb_atomic_event_ctrl.sv
module tb_atomic_event_ctrl;
    localparam int AW = 12;
    localparam int DW = 8;
    localparam int SD = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_op = 2'd3;
    logic req_lock = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic own_nak = 1'b0;
    logic snp_valid = 1'b0;
    logic [AW-1:0] snp_addr = '0;
    logic snp_nak, evt_active, evt_guarded, evt_done, mem_we;
    logic [1:0] evt_result;
    logic [SD-1:0] mem_wmask;
    logic [SD*AW-1:0] mem_waddr;
    logic [SD*DW-1:0] mem_wdata;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [AW-1:0] exp_a [SD];
    logic [DW-1:0] exp_d [SD];
    int exp_n;

    always #5 clk = ~clk;

    atomic_event_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_lock(req_lock), .req_addr(req_addr), .req_data(req_data),
        .own_nak(own_nak), .snp_valid(snp_valid), .snp_addr(snp_addr),
        .snp_nak(snp_nak), .evt_active(evt_active), .evt_guarded(evt_guarded),
        .evt_done(evt_done), .evt_result(evt_result), .mem_we(mem_we),
        .mem_wmask(mem_wmask), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
    );

    function automatic logic [AW-1:0] adr(input int line, input int ofs);
        return AW'((line << 2) | (ofs & 3));
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic req(input logic [1:0] op, input logic lk, input logic [AW-1:0] a,
                       input logic [DW-1:0] d);
        req_valid = 1'b1; req_op = op; req_lock = lk; req_addr = a; req_data = d;
        @(negedge clk);
        req_valid = 1'b0; req_lock = 1'b0; req_op = 2'd3;
    endtask

    task automatic snoop(input logic [AW-1:0] a, input int exp_nak, input string tag);
        snp_valid = 1'b1; snp_addr = a;
        #1;
        check(tag, int'(snp_nak), exp_nak);
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    task automatic model_store(input logic [AW-1:0] a, input logic [DW-1:0] d);
        bit found = 0;
        for (int i = 0; i < exp_n; i++) begin
            if (exp_a[i] == a) begin exp_d[i] = d; found = 1; end
        end
        if (!found) begin exp_a[exp_n] = a; exp_d[exp_n] = d; exp_n++; end
    endtask

    task automatic check_commit(input string tag);
        check({tag, " mem_we"}, int'(mem_we), 1);
        check({tag, " done"}, int'(evt_done), 1);
        check({tag, " result"}, int'(evt_result), 1);
        check({tag, " mask"}, int'(mem_wmask), (1 << exp_n) - 1);
        for (int i = 0; i < exp_n; i++) begin
            check({tag, " slot addr"}, int'(mem_waddr[i*AW +: AW]), int'(exp_a[i]));
            check({tag, " slot data"}, int'(mem_wdata[i*DW +: DW]), int'(exp_d[i]));
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #1_500_000;
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        check("R12 active", int'(evt_active), 0);
        check("R12 guarded", int'(evt_guarded), 0);
        check("R12 done", int'(evt_done), 0);
        check("R12 mem_we", int'(mem_we), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 done after release", int'(evt_done), 0);

        // R1/R2/R3/R4/R8/R10: sweep over 1..8 participating lines
        for (int nl = 1; nl <= 8; nl++) begin
            int base = nl * 16;
            exp_n = 0;
            for (int k = 0; k < nl; k++) begin
                req(2'd0, 1'b0, adr(base + k, k), 8'h00);
                check("R1 active after load", int'(evt_active), 1);
                check("R1 no outcome while loading", int'(evt_done), 0);
            end
            req(2'd0, 1'b0, adr(base, 3), 8'h00);
            check("R2 same-line load takes no entry", int'(evt_done), 0);
            if (nl % 2 == 1) begin
                req(2'd2, 1'b0, '0, 8'h00);
                check("R8 guarded after query", int'(evt_guarded), 1);
            end
            for (int k = 0; k < nl; k++) begin
                logic [DW-1:0] d = DW'(nl * 16 + k);
                req(2'd1, 1'b0, adr(base + k, k + 1), d);
                model_store(adr(base + k, k + 1), d);
                check("R3 no write mid-event", int'(mem_we), 0);
            end
            req(2'd1, 1'b0, adr(900, 0), 8'hEE);
            check("R2 foreign store ignored", int'(evt_done), 0);
            if (nl % 2 == 1) snoop(adr(base + nl - 1, 2), 1, "R8 guarded hit refused");
            else             snoop(adr(800, 0), 0, "R10 miss not refused");
            check("R10/R8 event continues", int'(evt_active), 1);
            req(2'd1, 1'b1, adr(base, 1), DW'(8'hA0 + nl));
            model_store(adr(base, 1), DW'(8'hA0 + nl));
            check_commit("R4 commit");
            @(negedge clk);
            check("R4 single-cycle write", int'(mem_we), 0);
            check("R11 idle after commit", int'(evt_active), 0);
        end

        // R1: ninth distinct line
        for (int k = 0; k < 8; k++) req(2'd0, 1'b0, adr(100 + k, 0), 8'h00);
        check("R1 eight lines accepted", int'(evt_active), 1);
        req(2'd0, 1'b0, adr(108, 0), 8'h00);
        check("R1 ninth line done", int'(evt_done), 1);
        check("R1 ninth line divert", int'(evt_result), 3);
        check("R1 inactive after divert", int'(evt_active), 0);
        @(negedge clk);

        // R5: store buffer overflow
        req(2'd0, 1'b0, adr(200, 0), 8'h00);
        req(2'd0, 1'b0, adr(201, 0), 8'h00);
        req(2'd0, 1'b0, adr(202, 0), 8'h00);
        for (int k = 0; k < 8; k++) req(2'd1, 1'b0, adr(200 + k / 4, k), DW'(k));
        check("R5 eight slots fill", int'(evt_done), 0);
        req(2'd1, 1'b0, adr(202, 0), 8'h33);
        check("R5 overflow done", int'(evt_done), 1);
        check("R5 overflow divert", int'(evt_result), 3);
        check("R3 no write on failure", int'(mem_we), 0);
        @(negedge clk);

        // R6: locked store to a line that has not joined
        req(2'd0, 1'b0, adr(300, 0), 8'h00);
        req(2'd1, 1'b0, adr(300, 1), 8'h11);
        req(2'd1, 1'b1, adr(301, 0), 8'h22);
        check("R6 abandon result", int'(evt_result), 3);
        check("R6 no write", int'(mem_we), 0);
        @(negedge clk);

        // R7: unguarded hit snoop restarts
        req(2'd0, 1'b0, adr(400, 0), 8'h00);
        req(2'd1, 1'b0, adr(400, 0), 8'h44);
        snoop(adr(400, 2), 0, "R7 unguarded hit not refused");
        check("R7 restart done", int'(evt_done), 1);
        check("R7 restart result", int'(evt_result), 2);
        @(negedge clk);

        // R8: own NAK while guarded diverts
        req(2'd0, 1'b0, adr(500, 0), 8'h00);
        req(2'd2, 1'b0, '0, 8'h00);
        own_nak = 1'b1; @(negedge clk); own_nak = 1'b0;
        check("R8 guarded own nak result", int'(evt_result), 3);
        @(negedge clk);

        // R9: own NAK unguarded restarts; idle has no effect
        req(2'd0, 1'b0, adr(510, 0), 8'h00);
        own_nak = 1'b1; @(negedge clk); own_nak = 1'b0;
        check("R9 unguarded own nak result", int'(evt_result), 2);
        @(negedge clk);
        own_nak = 1'b1; @(negedge clk); own_nak = 1'b0;
        check("R9 idle own nak no outcome", int'(evt_done), 0);
        check("R9 idle own nak stays idle", int'(evt_active), 0);

        // R11: previous lines forgotten
        snoop(adr(510, 0), 0, "R11 idle snoop not refused");
        exp_n = 0;
        req(2'd0, 1'b0, adr(600, 0), 8'h00);
        req(2'd2, 1'b0, '0, 8'h00);
        snoop(adr(510, 0), 0, "R11 old line not refused");
        snoop(adr(600, 3), 1, "R11 new line refused");
        req(2'd1, 1'b0, adr(510, 1), 8'h99);
        req(2'd1, 1'b0, adr(600, 0), 8'h55);
        model_store(adr(600, 0), 8'h55);
        req(2'd1, 1'b1, adr(600, 1), 8'h66);
        model_store(adr(600, 1), 8'h66);
        check_commit("R11 fresh commit");
        @(negedge clk);

        finish_run();
    end
endmodule